// File: doc/BRIEF.md
# Unsigned-Operand Accumulator Subtract Unit

This block is the execute slice of a 32-bit accumulator datapath for one instruction. That instruction subtracts a 16-bit data word from the accumulator. The word is always zero-extended, so the sign-extension mode flag has no effect on it. The accumulator takes part as a signed value. The difference is written back to the accumulator. The carry flag is set when the subtraction needs no borrow and cleared when it does. An overflow flag records any signed overflow. The overflow-mode input selects whether an overflowed result saturates or wraps.

Each cycle the surrounding pipeline presents the current accumulator, the operand word, the instruction word, the two mode flags and a valid strobe. The unit fires when the strobe is high and the instruction's upper byte matches the opcode parameter. On that clock edge it registers the new accumulator and flags, so the result is available one cycle later. The unit also splits the instruction word into its direct-address and indirect-update fields, which the address-generation logic uses.

Top module: `acc_usub_unit`

## Requirements
- R1: The operand is zero-extended to 32 bits whatever `sext_mode_i` says. Without overflow, or with `ovf_mode_i` = 0, the registered accumulator equals `acc_i` − operand, modulo 2^32.
- R2: After a firing edge, `carry_o` is 1 when `acc_i`, read as unsigned, is greater than or equal to the operand (no borrow). It is 0 otherwise.
- R3: A firing edge whose signed result falls outside the 32-bit signed range sets `ovf_o`. Because the operand is never negative, this happens only when `acc_i` is negative and the true difference is below −2^31.
- R4: `ovf_o` is sticky. An edge with `ovf_clr_i` = 1 clears it. If an overflow happens on the same edge, the set wins and `ovf_o` is 1.
- R5: With `ovf_mode_i` = 1, an overflowed result is stored as 0x8000_0000 when the true difference is negative, and as 0x7FFF_FFFF when it is positive.
- R6: With `ovf_mode_i` = 0, an overflowed result wraps to the low 32 bits of the difference.
- R7: The unit fires only when `valid_i` = 1 and `insn_i[15:8]` equals `SUB_OPC` (default 0x64). On any other edge, `acc_o` and `carry_o` hold, and `ovf_o` changes only by clearing.
- R8: A synchronous active-high `rst` clears `acc_o`, `carry_o` and `ovf_o`.
- R9: Decode runs without a clock. `ind_o` equals `insn_i[7]`.
  - When bit 7 is 0, `dma_o` equals bits 6:0, and `upd_o`, `nflag_o` and `nreg_o` are 0.
  - When bit 7 is 1, `upd_o` equals bits 6:4, `nflag_o` equals bit 3, `nreg_o` equals bits 2:0, and `dma_o` is 0.
  - `hit_o` is 1 when bits 15:8 equal `SUB_OPC`.
- R10: The accumulator and flags reflect a firing operation right after that single clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| insn_i | input | 16 | Instruction word |
| acc_i | input | 32 | Current accumulator |
| operand_i | input | 16 | Data-memory operand |
| sext_mode_i | input | 1 | Sign-extension mode flag (ignored) |
| ovf_mode_i | input | 1 | 1 = saturate on overflow, 0 = wrap |
| ovf_clr_i | input | 1 | Clears the sticky overflow flag |
| acc_o | output | 32 | Registered new accumulator |
| carry_o | output | 1 | Registered carry (1 = no borrow) |
| ovf_o | output | 1 | Sticky overflow flag |
| hit_o | output | 1 | Opcode match |
| ind_o | output | 1 | Indirect form |
| dma_o | output | 7 | Direct address offset |
| upd_o | output | 3 | Indirect update code |
| nflag_o | output | 1 | Next-register select flag |
| nreg_o | output | 3 | Next-register number |

## Verification
Overflow is the hard condition to reach. With a non-negative operand, it occurs only for accumulators close to −2^31, so random stimulus almost never produces it. The bench therefore sets up explicit accumulator values just above 0x8000_0000 and runs them in both overflow modes. It also makes an overflow and a flag clear arrive on the same edge. The random phase biases half of its accumulators toward that corner. A behavioural model using 64-bit integers predicts every cycle's outputs.

// File: rtl/acc_usub_pkg.sv
package acc_usub_pkg;
    localparam int ACC_W  = 32;
    localparam int OPR_W  = 16;
    localparam int INSN_W = 16;
    localparam int OPC_W  = 8;
    localparam int OFF_W  = 7;
    localparam int UPD_W  = 3;
    localparam int REG_W  = 3;
    localparam int EXT_W  = ACC_W + 1;

    typedef struct packed {
        logic             hit;
        logic             ind;
        logic [OFF_W-1:0] off;
        logic [UPD_W-1:0] upd;
        logic             nflag;
        logic [REG_W-1:0] nreg;
    } insn_fields_t;

    typedef struct packed {
        logic [ACC_W-1:0] res;
        logic             carry;
        logic             ovf;
    } alu_res_t;

    localparam logic [ACC_W-1:0] SAT_NEG = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic [ACC_W-1:0] SAT_POS = {1'b0, {(ACC_W-1){1'b1}}};

    // Signed accumulator minus an unsigned operand
    function automatic alu_res_t usub_calc(
        input logic [ACC_W-1:0] acc,
        input logic [OPR_W-1:0] opr,
        input logic             sat_en
    );
        alu_res_t         r;
        logic [EXT_W-1:0] sdiff;
        logic [EXT_W-1:0] udiff;
        logic [EXT_W-1:0] opr_ext;
        opr_ext = {{(EXT_W-OPR_W){1'b0}}, opr};
        sdiff   = {acc[ACC_W-1], acc} - opr_ext;
        udiff   = {1'b0, acc} - opr_ext;
        r.carry = ~udiff[EXT_W-1];
        r.ovf   = sdiff[EXT_W-1] ^ sdiff[EXT_W-2];
        if (r.ovf && sat_en)
            r.res = sdiff[EXT_W-1] ? SAT_NEG : SAT_POS;
        else
            r.res = sdiff[ACC_W-1:0];
        return r;
    endfunction
endpackage

// File: rtl/usub_decode.sv
module usub_decode
    import acc_usub_pkg::*;
#(
    parameter logic [OPC_W-1:0] SUB_OPC = 8'h64
) (
    input  logic [INSN_W-1:0] insn,
    output insn_fields_t      flds
);
    localparam int MODE_BIT = OFF_W;

    always_comb begin
        flds       = '0;
        flds.hit   = (insn[INSN_W-1 -: OPC_W] == SUB_OPC);
        flds.ind   = insn[MODE_BIT];
        if (insn[MODE_BIT]) begin
            flds.upd   = insn[REG_W+1 +: UPD_W];
            flds.nflag = insn[REG_W];
            flds.nreg  = insn[REG_W-1:0];
        end else begin
            flds.off   = insn[OFF_W-1:0];
        end
    end
endmodule

// File: rtl/usub_alu.sv
module usub_alu
    import acc_usub_pkg::*;
(
    input  logic [ACC_W-1:0] acc,
    input  logic [OPR_W-1:0] opr,
    input  logic             sat_en,
    output alu_res_t         res
);
    always_comb res = usub_calc(acc, opr, sat_en);
endmodule

// File: rtl/usub_state.sv
module usub_state
    import acc_usub_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic             ovf_clr,
    input  alu_res_t         nxt,
    output logic [ACC_W-1:0] acc_q,
    output logic             carry_q,
    output logic             ovf_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            if (fire) begin
                acc_q   <= nxt.res;
                carry_q <= nxt.carry;
            end
            if (fire && nxt.ovf)
                ovf_q <= 1'b1;
            else if (ovf_clr)
                ovf_q <= 1'b0;
        end
    end
endmodule

// File: rtl/acc_usub_unit.sv
module acc_usub_unit
    import acc_usub_pkg::*;
#(
    parameter logic [OPC_W-1:0] SUB_OPC = 8'h64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [INSN_W-1:0] insn_i,
    input  logic [ACC_W-1:0]  acc_i,
    input  logic [OPR_W-1:0]  operand_i,
    input  logic              sext_mode_i,
    input  logic              ovf_mode_i,
    input  logic              ovf_clr_i,
    output logic [ACC_W-1:0]  acc_o,
    output logic              carry_o,
    output logic              ovf_o,
    output logic              hit_o,
    output logic              ind_o,
    output logic [OFF_W-1:0]  dma_o,
    output logic [UPD_W-1:0]  upd_o,
    output logic              nflag_o,
    output logic [REG_W-1:0]  nreg_o
);
    insn_fields_t flds;
    alu_res_t     alu;
    logic         fire;

    usub_decode #(.SUB_OPC(SUB_OPC)) u_dec (
        .insn (insn_i),
        .flds (flds)
    );

    // sext_mode_i deliberately does not reach the datapath
    usub_alu u_alu (
        .acc    (acc_i),
        .opr    (operand_i),
        .sat_en (ovf_mode_i),
        .res    (alu)
    );

    assign fire = valid_i & flds.hit;

    usub_state u_st (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .ovf_clr (ovf_clr_i),
        .nxt     (alu),
        .acc_q   (acc_o),
        .carry_q (carry_o),
        .ovf_q   (ovf_o)
    );

    assign hit_o   = flds.hit;
    assign ind_o   = flds.ind;
    assign dma_o   = flds.off;
    assign upd_o   = flds.upd;
    assign nflag_o = flds.nflag;
    assign nreg_o  = flds.nreg;
endmodule

// File: rtl/acc_usub_checker.sv
module acc_usub_checker
    import acc_usub_pkg::*;
#(
    parameter logic [OPC_W-1:0] SUB_OPC = 8'h64
) (
    input logic              clk,
    input logic              rst,
    input logic              valid_i,
    input logic [INSN_W-1:0] insn_i,
    input logic [ACC_W-1:0]  acc_i,
    input logic [OPR_W-1:0]  operand_i,
    input logic              sext_mode_i,
    input logic              ovf_mode_i,
    input logic              ovf_clr_i,
    input logic [ACC_W-1:0]  acc_o,
    input logic              carry_o,
    input logic              ovf_o
);
    logic go;
    assign go = valid_i && (insn_i[INSN_W-1 -: OPC_W] == SUB_OPC);

    // R1: operand zero-extended even with sign-extension mode on
    a_r1_zero_ext: assert property (@(posedge clk) disable iff (rst)
        go && sext_mode_i && !ovf_mode_i |=>
            acc_o == $past(acc_i) - {{(ACC_W-OPR_W){1'b0}}, $past(operand_i)});

    // R2: carry is the no-borrow indication
    a_r2_carry: assert property (@(posedge clk) disable iff (rst)
        go |=> carry_o == ($past(acc_i) >= {{(ACC_W-OPR_W){1'b0}}, $past(operand_i)}));

    // R3: a non-negative accumulator can never overflow here
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        go && !acc_i[ACC_W-1] && !ovf_o && !ovf_clr_i |=> !ovf_o);

    // R4: overflow flag is sticky without a clear
    a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_o && !ovf_clr_i |=> ovf_o);

    // R5: saturating mode keeps a negative accumulator negative
    a_r5_sat_sign: assert property (@(posedge clk) disable iff (rst)
        go && ovf_mode_i && acc_i[ACC_W-1] |=> acc_o[ACC_W-1]);

    // R7: no change on idle edges
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !go |=> $stable(acc_o) && $stable(carry_o));

    // R4: clear without a firing operation drops the flag
    a_r4_clear: assert property (@(posedge clk) disable iff (rst)
        ovf_clr_i && !go |=> !ovf_o);
endmodule

bind acc_usub_unit acc_usub_checker #(.SUB_OPC(SUB_OPC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .valid_i     (valid_i),
    .insn_i      (insn_i),
    .acc_i       (acc_i),
    .operand_i   (operand_i),
    .sext_mode_i (sext_mode_i),
    .ovf_mode_i  (ovf_mode_i),
    .ovf_clr_i   (ovf_clr_i),
    .acc_o       (acc_o),
    .carry_o     (carry_o),
    .ovf_o       (ovf_o)
);

// File: tb/acc_usub_unit_bench.sv
module acc_usub_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] OPC = 8'h64;

    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [15:0] insn_i;
    logic [31:0] acc_i;
    logic [15:0] operand_i;
    logic        sext_mode_i, ovf_mode_i, ovf_clr_i;
    logic [31:0] acc_o;
    logic        carry_o, ovf_o, hit_o, ind_o, nflag_o;
    logic [6:0]  dma_o;
    logic [2:0]  upd_o, nreg_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [31:0] m_acc;
    logic        m_carry, m_ovf;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_usub_unit #(.SUB_OPC(OPC)) u_acc_usub_unit (
        .clk(clk), .rst(rst), .valid_i(valid_i), .insn_i(insn_i), .acc_i(acc_i),
        .operand_i(operand_i), .sext_mode_i(sext_mode_i), .ovf_mode_i(ovf_mode_i),
        .ovf_clr_i(ovf_clr_i), .acc_o(acc_o), .carry_o(carry_o), .ovf_o(ovf_o),
        .hit_o(hit_o), .ind_o(ind_o), .dma_o(dma_o), .upd_o(upd_o),
        .nflag_o(nflag_o), .nreg_o(nreg_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural reference for one edge
    task automatic model_edge();
        longint d;
        bit     fire, ov;
        fire = valid_i && (insn_i[15:8] == OPC);
        if (rst) begin
            m_acc = 0; m_carry = 0; m_ovf = 0;
            return;
        end
        ov = 0;
        if (fire) begin
            d  = longint'($signed(acc_i)) - longint'(operand_i);
            ov = (d < -(64'sd1 <<< 31)) || (d > ((64'sd1 <<< 31) - 1));
            m_carry = ({32'd0, acc_i} >= {48'd0, operand_i});
            if (ov && ovf_mode_i) m_acc = (d < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
            else                  m_acc = d[31:0];
        end
        if (ov)             m_ovf = 1;
        else if (ovf_clr_i) m_ovf = 0;
    endtask

    task automatic step(input string req, input bit v, input logic [15:0] ins,
                        input logic [31:0] a, input logic [15:0] op,
                        input bit sx, input bit om, input bit clr);
        valid_i = v; insn_i = ins; acc_i = a; operand_i = op;
        sext_mode_i = sx; ovf_mode_i = om; ovf_clr_i = clr;
        #1;
        // R9 decode, combinational
        check(hit_o == (ins[15:8] == OPC), "R9 hit", {31'd0, hit_o}, {31'd0, ins[15:8] == OPC});
        check(ind_o == ins[7], "R9 mode", {31'd0, ind_o}, {31'd0, ins[7]});
        check({dma_o, upd_o, nflag_o, nreg_o} ==
              (ins[7] ? {7'd0, ins[6:0]} : {ins[6:0], 7'd0}), "R9 fields",
              {18'd0, dma_o, upd_o, nflag_o, nreg_o},
              {18'd0, ins[7] ? {7'd0, ins[6:0]} : {ins[6:0], 7'd0}});
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(acc_o == m_acc, {req, " acc (R1 R10)"}, acc_o, m_acc);
        check(carry_o == m_carry, {req, " carry R2"}, {31'd0, carry_o}, {31'd0, m_carry});
        check(ovf_o == m_ovf, {req, " ovf R3"}, {31'd0, ovf_o}, {31'd0, m_ovf});
    endtask

    localparam logic [15:0] DIR = {8'h64, 1'b0, 7'h2A};
    localparam logic [15:0] IND = {8'h64, 1'b1, 3'd5, 1'b1, 3'd6};

    initial begin
        m_acc = 0; m_carry = 0; m_ovf = 0;
        rst = 1;
        step("R8 reset", 1, DIR, 32'h1234_5678, 16'h0001, 0, 0, 0);
        check(acc_o == 0 && !carry_o && !ovf_o, "R8 reset state", acc_o, 0);
        rst = 0;
        step("R1 basic", 1, DIR, 32'd100, 16'd30, 0, 0, 0);
        step("R1 sxm ignored", 1, IND, 32'd100, 16'h8000, 1, 0, 0);
        check(acc_o == 32'hFFFF_8064, "R1 zero-extend", acc_o, 32'hFFFF_8064);
        step("R2 borrow", 1, DIR, 32'd5, 16'd10, 0, 0, 0);
        check(carry_o == 0 && acc_o == 32'hFFFF_FFFB, "R2 borrow", acc_o, 32'hFFFF_FFFB);
        step("R2 equal", 1, DIR, 32'd7, 16'd7, 0, 0, 0);
        check(carry_o == 1 && acc_o == 0, "R2 equal no borrow", {31'd0, carry_o}, 1);
        step("R2 neg acc", 1, DIR, 32'hFFFF_0000, 16'hFFFF, 1, 1, 0);
        step("R6 wrap", 1, DIR, 32'h8000_0000, 16'd1, 0, 0, 0);
        check(acc_o == 32'h7FFF_FFFF && ovf_o, "R6 wrap", acc_o, 32'h7FFF_FFFF);
        step("R4 sticky", 1, DIR, 32'd50, 16'd1, 0, 0, 0);
        check(ovf_o == 1, "R4 sticky", {31'd0, ovf_o}, 1);
        step("R4 clear", 0, DIR, 32'd0, 16'd0, 0, 0, 1);
        check(ovf_o == 0, "R4 clear", {31'd0, ovf_o}, 0);
        step("R5 sat", 1, IND, 32'h8000_0005, 16'hFFFF, 0, 1, 0);
        check(acc_o == 32'h8000_0000 && ovf_o, "R5 saturate", acc_o, 32'h8000_0000);
        step("R4 set beats clear", 1, DIR, 32'h8000_0000, 16'd2, 0, 1, 1);
        check(ovf_o == 1, "R4 set wins", {31'd0, ovf_o}, 1);
        step("R3 edge no ovf", 1, DIR, 32'h8000_FFFF, 16'hFFFF, 0, 1, 1);
        check(ovf_o == 0 && acc_o == 32'h8000_0000, "R3 boundary", acc_o, 32'h8000_0000);
        step("R7 invalid", 0, DIR, 32'd999, 16'd1, 0, 0, 0);
        check(acc_o == 32'h8000_0000, "R7 hold on invalid", acc_o, 32'h8000_0000);
        step("R7 opcode miss", 1, 16'h6580, 32'd999, 16'd1, 0, 0, 0);
        check(acc_o == 32'h8000_0000, "R7 hold on mismatch", acc_o, 32'h8000_0000);
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            a = $urandom;
            if (i % 2 == 0) a = {16'h8000, a[15:0]};
            step("RND", ($urandom % 4) != 0,
                 (($urandom % 5) == 0) ? 16'($urandom) : {OPC, 8'($urandom)},
                 a, 16'($urandom), 1'($urandom), 1'($urandom), ($urandom % 6) == 0);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule